// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block receives asynchronous serial characters on a single line. A free-running oversampling strobe supplied from outside paces it: the block finds the falling edge of a start bit, counts samples through every bit period, and decides each bit by a majority of the three samples around the bit centre. It assembles 5 to 9 data bits, least significant first. It then checks an optional even or odd parity bit and the first stop bit.

Completed characters enter a two-entry buffer. Each entry carries its data, its ninth bit and its own framing, parity and overrun flags. The host sees the oldest entry on the outputs and removes it with a one-cycle read strobe.

In multiprocessor mode, a ninth bit of 1 marks an address character. The block always stores address characters, and it compares their low eight bits with a node address. Data characters that follow are stored only while the last address matched.

Top module: `async_rx_addr`

## Requirements
- R1: After reset, and whenever the buffer is empty, rx_valid_o, rx_bit8_o, rx_data_o and all three error outputs are 0.
- R2: A start is accepted only if the majority of the three centre samples of the start bit is low. Otherwise the receiver returns to hunting and stores nothing.
- R3: Data bits are received least significant first. char_size_i selects the length: 3'b000=5, 3'b001=6, 3'b010=7, 3'b011=8, 3'b111=9, and any other code selects 8. Bits above the selected length read as 0.
- R4: Each bit takes the majority of the samples at positions half-1, half and half+1 of its period, where half is the samples per bit divided by 2. A single deviating centre sample does not change the bit.
- R5: parity_mode_i 2'b10 selects even parity and 2'b11 selects odd parity; 2'b00 and 2'b01 mean no parity bit. With even parity, parity_err_o is set when the data ones plus the parity bit give an odd count. With odd parity, it is set when that count is even.
- R6: A first stop bit that is voted low sets frame_err_o on that character, which is still stored. Only the first stop bit is checked.
- R7: The buffer holds two characters in arrival order. A high rd_i while rx_valid_o is high removes the oldest entry, and the outputs then show the next one. Without a read, the head entry stays unchanged.
- R8: A character that completes while both entries are full and no read occurs in that cycle is discarded. The newest stored entry then gets overrun_o set.
- R9: A character is written on the second clock edge after the oversampling tick that takes its last stop-bit centre sample. If rd_i is high on that same edge with the buffer full, the read and the write both take effect and no overrun is flagged.
- R10: For 9-bit characters, rx_bit8_o shows the head entry's ninth bit. It is removed by the same read as rx_data_o.
- R11: With mpcm_en_i high and 9-bit size, a ninth bit of 1 marks an address character. Address characters are always stored, and their low 8 bits are compared with node_addr_i. A data character (ninth bit 0) is stored only if the most recent address character matched. After reset, no address has matched.
- R12: dbl_speed_i high uses 8 samples per bit; low uses 16.
- R13: While rx_en_i is low, the line is ignored and any character in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle oversampling strobe |
| dbl_speed_i | input | 1 | 8 samples per bit instead of 16 |
| char_size_i | input | 3 | Data length code |
| parity_mode_i | input | 2 | Parity selection |
| mpcm_en_i | input | 1 | Multiprocessor address filtering |
| node_addr_i | input | 8 | Address that opens the data gate |
| rd_i | input | 1 | Pop the head entry |
| rx_valid_o | output | 1 | Buffer holds at least one character |
| rx_data_o | output | 8 | Head entry, low 8 data bits |
| rx_bit8_o | output | 1 | Head entry, ninth data bit |
| frame_err_o | output | 1 | Head entry stop bit was low |
| parity_err_o | output | 1 | Head entry parity mismatch |
| overrun_o | output | 1 | A character was lost after the head-side entry |

## Verification
The delicate overlap is a character completing in the same cycle as a host read while both buffer entries are full. Which one happens first decides whether a character is lost.

The bench fills the buffer and then sends a third character. From its own tick count, it places a single read pulse exactly on the edge where that character is written. It judges the result by checking three things: the head moves to the second character, that character carries no overrun flag, and the third character is delivered afterwards.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef struct packed {
    logic [8:0] dat;
    logic       fe;
    logic       pe;
    logic       ovr;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [2:0] SIZE_NINE = 3'b111;

  function automatic logic [3:0] data_len(input logic [2:0] code);
    case (code)
      3'b000:  data_len = 4'd5;
      3'b001:  data_len = 4'd6;
      3'b010:  data_len = 4'd7;
      3'b111:  data_len = 4'd9;
      default: data_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler #(
  parameter int OSR_NORMAL = 16,
  parameter int OSR_DOUBLE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic dbl_i,
  input  logic hunt_i,
  input  logic arm_i,
  output logic start_o,
  output logic bit_stb_o,
  output logic bit_o
);

  localparam int CW = $clog2(OSR_NORMAL);

  logic [CW-1:0] cnt_q, last, mid, mid_lo, mid_hi;
  logic [1:0]    smp_q;
  logic          hunting, vote;

  assign last    = dbl_i ? CW'(OSR_DOUBLE - 1) : CW'(OSR_NORMAL - 1);
  assign mid     = dbl_i ? CW'(OSR_DOUBLE / 2) : CW'(OSR_NORMAL / 2);
  assign mid_lo  = mid - 1'b1;
  assign mid_hi  = mid + 1'b1;
  // framer lags start_o by one cycle
  assign hunting = hunt_i && !start_o;
  assign vote    = (smp_q[0] & smp_q[1]) | (smp_q[0] & line_i) | (smp_q[1] & line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      smp_q     <= '0;
      start_o   <= 1'b0;
      bit_stb_o <= 1'b0;
      bit_o     <= 1'b1;
    end else begin
      start_o   <= 1'b0;
      bit_stb_o <= 1'b0;
      if (hunting) begin
        cnt_q <= '0;
        if (tick_i && arm_i && !line_i) begin
          cnt_q   <= CW'(1);
          start_o <= 1'b1;
        end
      end else if (tick_i) begin
        cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        if (cnt_q == mid_lo) smp_q[0] <= line_i;
        if (cnt_q == mid)    smp_q[1] <= line_i;
        if (cnt_q == mid_hi) begin
          bit_stb_o <= 1'b1;
          bit_o     <= vote;
        end
      end
    end
  end

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       bit_stb_i,
  input  logic       bit_i,
  input  logic [2:0] size_i,
  input  logic [1:0] par_i,
  input  logic       mpcm_i,
  input  logic [7:0] addr_i,
  output logic       hunt_o,
  output logic       push_o,
  output rx_char_t   char_o
);

  rx_state_e  st_q;
  logic [8:0] sh_q;
  logic [3:0] idx_q, len;
  logic       acc_q, pbit_q, match_q;
  logic       par_en, mp_eff, is_addr, keep;

  assign len     = data_len(size_i);
  assign par_en  = par_i[1];
  assign mp_eff  = mpcm_i && (size_i == SIZE_NINE);
  assign is_addr = mp_eff && sh_q[8];
  assign keep    = !mp_eff || sh_q[8] || match_q;
  assign hunt_o  = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      acc_q   <= 1'b0;
      pbit_q  <= 1'b0;
      match_q <= 1'b0;
      push_o  <= 1'b0;
      char_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (start_i) begin
            st_q  <= ST_START;
            sh_q  <= '0;
            idx_q <= '0;
            acc_q <= 1'b0;
          end
          ST_START: if (bit_stb_i) st_q <= bit_i ? ST_IDLE : ST_DATA;
          ST_DATA: if (bit_stb_i) begin
            sh_q[idx_q] <= bit_i;
            acc_q       <= acc_q ^ bit_i;
            idx_q       <= idx_q + 4'd1;
            if (idx_q == len - 4'd1) st_q <= par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: if (bit_stb_i) begin
            pbit_q <= bit_i;
            st_q   <= ST_STOP;
          end
          ST_STOP: if (bit_stb_i) begin
            st_q       <= ST_IDLE;
            push_o     <= keep;
            char_o.dat <= sh_q;
            char_o.fe  <= !bit_i;
            char_o.pe  <= par_en && (acc_q ^ pbit_q ^ par_i[0]);
            char_o.ovr <= 1'b0;
            if (is_addr) match_q <= (sh_q[7:0] == addr_i);
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  rx_char_t   char_i,
  input  logic       pop_i,
  output logic       valid_o,
  output rx_char_t   head_o,
  output logic [1:0] fill_o
);

  rx_char_t   ent_q [2];
  logic       hd_q;
  logic [1:0] fill_q;
  logic       do_pop, full, take, lost, wr_idx;

  assign full   = (fill_q == 2'd2);
  assign do_pop = pop_i && (fill_q != 2'd0);
  assign take   = push_i && (!full || do_pop);
  assign lost   = push_i && full && !do_pop;
  assign wr_idx = hd_q ^ (fill_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q[0] <= '0;
      ent_q[1] <= '0;
      hd_q     <= 1'b0;
      fill_q   <= '0;
    end else begin
      if (do_pop) hd_q <= ~hd_q;
      if (take) ent_q[wr_idx] <= char_i;
      if (lost) ent_q[~hd_q].ovr <= 1'b1;
      fill_q <= fill_q + {1'b0, take} - {1'b0, do_pop};
    end
  end

  assign valid_o = (fill_q != 2'd0);
  assign head_o  = ent_q[hd_q];
  assign fill_o  = fill_q;

endmodule

// File: rtl/async_rx_addr.sv
module async_rx_addr
  import rx_pkg::*;
#(
  parameter int OSR_NORMAL  = 16,
  parameter int OSR_DOUBLE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       rx_i,
  input  logic       os_tick_i,
  input  logic       dbl_speed_i,
  input  logic [2:0] char_size_i,
  input  logic [1:0] parity_mode_i,
  input  logic       mpcm_en_i,
  input  logic [7:0] node_addr_i,
  input  logic       rd_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       rx_bit8_o,
  output logic       frame_err_o,
  output logic       parity_err_o,
  output logic       overrun_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic       line, hunt, start, bit_stb, bit_val, push, valid;
  logic [1:0] fill;
  rx_char_t   fr_char, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign line = sync_q[SYNC_STAGES-1];

  rx_sampler #(.OSR_NORMAL(OSR_NORMAL), .OSR_DOUBLE(OSR_DOUBLE)) u_smp (
    .clk_i, .rst_ni,
    .tick_i   (os_tick_i),
    .line_i   (line),
    .dbl_i    (dbl_speed_i),
    .hunt_i   (hunt),
    .arm_i    (rx_en_i),
    .start_o  (start),
    .bit_stb_o(bit_stb),
    .bit_o    (bit_val)
  );

  rx_framer u_frm (
    .clk_i, .rst_ni,
    .en_i     (rx_en_i),
    .start_i  (start),
    .bit_stb_i(bit_stb),
    .bit_i    (bit_val),
    .size_i   (char_size_i),
    .par_i    (parity_mode_i),
    .mpcm_i   (mpcm_en_i),
    .addr_i   (node_addr_i),
    .hunt_o   (hunt),
    .push_o   (push),
    .char_o   (fr_char)
  );

  rx_buffer u_buf (
    .clk_i, .rst_ni,
    .push_i (push),
    .char_i (fr_char),
    .pop_i  (rd_i),
    .valid_o(valid),
    .head_o (head),
    .fill_o (fill)
  );

  assign rx_valid_o   = valid;
  assign rx_data_o    = valid ? head.dat[7:0] : 8'h00;
  assign rx_bit8_o    = valid && head.dat[8];
  assign frame_err_o  = valid && head.fe;
  assign parity_err_o = valid && head.pe;
  assign overrun_o    = valid && head.ovr;

endmodule

// File: rtl/rx_checker.sv
module rx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       rd_i,
  input logic       rx_valid_o,
  input logic [7:0] rx_data_o,
  input logic       rx_bit8_o,
  input logic       frame_err_o,
  input logic       parity_err_o,
  input logic       overrun_o,
  input logic       push,
  input logic [1:0] fill,
  input logic       hunt
);

  a_r1_empty_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> (rx_data_o == 8'h00) && !rx_bit8_o && !frame_err_o && !parity_err_o && !overrun_o);

  a_r7_head_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rd_i) |=> rx_valid_o && $stable(rx_data_o) && $stable(rx_bit8_o) && $stable(frame_err_o));

  a_r7_fill_range: assert property (@(posedge clk_i) disable iff (!rst_ni) fill != 2'd3);

  a_r7_last_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fill == 2'd1 && !push) |=> !rx_valid_o);

  a_r8_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && fill == 2'd2 && !rd_i) |=> fill == 2'd2);

  a_r9_swap_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && fill == 2'd2 && rd_i) |=> fill == 2'd2);

  a_r13_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> hunt);

endmodule

bind async_rx_addr rx_checker i_rx_checker (
  .clk_i, .rst_ni, .rx_en_i, .rd_i, .rx_valid_o, .rx_data_o, .rx_bit8_o,
  .frame_err_o, .parity_err_o, .overrun_o,
  .push (push),
  .fill (fill),
  .hunt (hunt)
);

// File: tb/test_async_rx_addr.sv
module test_async_rx_addr;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni, line, tick, en, dbl, mpcm, rd_mon, rd_drv, rd;
  logic [2:0] size;
  logic [1:0] par;
  logic [7:0] addr;
  logic       rx_valid_o, rx_bit8_o, frame_err_o, parity_err_o, overrun_o;
  logic [7:0] rx_data_o;

  assign rd = rd_mon | rd_drv;

  async_rx_addr i_async_rx_addr (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(en), .rx_i(line), .os_tick_i(tick),
    .dbl_speed_i(dbl), .char_size_i(size), .parity_mode_i(par), .mpcm_en_i(mpcm),
    .node_addr_i(addr), .rd_i(rd), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_bit8_o(rx_bit8_o), .frame_err_o(frame_err_o), .parity_err_o(parity_err_o),
    .overrun_o(overrun_o)
  );

  typedef struct {
    logic [8:0] d;
    logic       fe, pe, ov;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, fails = 0;
  bit   hold = 1'b0;

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_char(input logic [8:0] d, input bit fe, input bit pe, input bit ov,
                             input string req);
    exp_t e;
    e.d = d; e.fe = fe; e.pe = pe; e.ov = ov; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  initial begin
    rd_mon = 1'b0;
    wait (rst_ni === 1'b1);
    forever begin
      @(negedge clk);
      if (rx_valid_o && !hold) begin
        if (q.size() == 0) begin
          cmp("R7", "unexpected character", {23'd0, rx_bit8_o, rx_data_o}, 'h1ff);
        end else begin
          exp_t e;
          e = q.pop_front();
          cmp(e.req, "data", {23'd0, rx_bit8_o, rx_data_o}, {23'd0, e.d});
          cmp(e.req, "frame_err", frame_err_o, e.fe);
          cmp(e.req, "parity_err", parity_err_o, e.pe);
          cmp(e.req, "overrun", overrun_o, e.ov);
        end
        rd_mon = 1'b1;
        @(negedge clk);
        rd_mon = 1'b0;
      end
    end
  end

  task automatic one_tick(input logic v, input bit rd_here);
    @(negedge clk); tick = 1'b1; line = v;
    @(negedge clk); tick = 1'b0;
    @(negedge clk); if (rd_here) rd_drv = 1'b1;
    @(negedge clk); rd_drv = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input bit pen, input bit podd,
                            input bit pflip, input logic stopv, input int gbit,
                            input bit rd_at_push);
    int   n, mid, js, total, ptick;
    logic bits [12];
    logic p;
    n   = dbl ? 8 : 16;
    mid = n / 2;
    bits[0] = 1'b0;
    p = podd ^ pflip;
    for (int j = 0; j < nb; j++) begin
      bits[1 + j] = d[j];
      p = p ^ d[j];
    end
    js = 1 + nb;
    if (pen) begin
      bits[js] = p;
      js++;
    end
    bits[js] = stopv;
    total = js + 1;
    ptick = js * n + mid + 2;
    for (int i = 0; i < total * n + 2 * n; i++) begin
      int   b;
      logic v;
      b = i / n;
      v = (b < total) ? bits[b] : 1'b1;
      if (b == gbit && (i % n) == mid) v = ~v;
      one_tick(v, rd_at_push && (i == ptick));
    end
  endtask

  task automatic drain;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (q.size() == 0 && !rx_valid_o) break;
    end
    cmp("R7", "pending expectations", q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; line = 1'b1; tick = 1'b0; en = 1'b1; dbl = 1'b0; mpcm = 1'b0;
    rd_drv = 1'b0; size = 3'b011; par = 2'b00; addr = 8'h3c;
    repeat (5) @(negedge clk);
    cmp("R1", "valid in reset", rx_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp("R1", "valid after reset", rx_valid_o, 0);
    cmp("R1", "flags after reset", {frame_err_o, parity_err_o, overrun_o, rx_bit8_o}, 0);
    cmp("R1", "data after reset", rx_data_o, 0);

    // R3: 8-bit frames, several patterns
    expect_char(9'h055, 0, 0, 0, "R3"); send_frame(9'h055, 8, 0, 0, 0, 1, -1, 0);
    expect_char(9'h0a3, 0, 0, 0, "R3"); send_frame(9'h0a3, 8, 0, 0, 0, 1, -1, 0);
    expect_char(9'h0ff, 0, 0, 0, "R3"); send_frame(9'h0ff, 8, 0, 0, 0, 1, -1, 0);
    expect_char(9'h000, 0, 0, 0, "R3"); send_frame(9'h000, 8, 0, 0, 0, 1, -1, 0);
    // R3: short sizes, upper bits zero
    size = 3'b000;
    expect_char(9'h016, 0, 0, 0, "R3_5bit"); send_frame(9'h0f6, 5, 0, 0, 0, 1, -1, 0);
    size = 3'b010;
    expect_char(9'h07f, 0, 0, 0, "R3_7bit"); send_frame(9'h0ff, 7, 0, 0, 0, 1, -1, 0);
    size = 3'b011;
    drain();

    // R4: one corrupted centre sample in data bits
    expect_char(9'h05a, 0, 0, 0, "R4"); send_frame(9'h05a, 8, 0, 0, 0, 1, 3, 0);
    expect_char(9'h0c3, 0, 0, 0, "R4"); send_frame(9'h0c3, 8, 0, 0, 0, 1, 8, 0);

    // R5: parity
    par = 2'b10;
    expect_char(9'h0b7, 0, 0, 0, "R5_even_ok");  send_frame(9'h0b7, 8, 1, 0, 0, 1, -1, 0);
    expect_char(9'h0b7, 0, 1, 0, "R5_even_bad"); send_frame(9'h0b7, 8, 1, 0, 1, 1, -1, 0);
    par = 2'b11;
    expect_char(9'h031, 0, 0, 0, "R5_odd_ok");   send_frame(9'h031, 8, 1, 1, 0, 1, -1, 0);
    expect_char(9'h031, 0, 1, 0, "R5_odd_bad");  send_frame(9'h031, 8, 1, 1, 1, 1, -1, 0);
    par = 2'b00;

    // R6: framing error, character kept
    expect_char(9'h0e4, 1, 0, 0, "R6"); send_frame(9'h0e4, 8, 0, 0, 0, 0, -1, 0);
    expect_char(9'h012, 0, 0, 0, "R6_recover"); send_frame(9'h012, 8, 0, 0, 0, 1, -1, 0);
    drain();

    // R2: false start (line low for 4 samples only)
    for (int k = 0; k < 40; k++) one_tick(k < 4 ? 1'b0 : 1'b1, 0);
    cmp("R2", "false start stored", rx_valid_o, 0);

    // R13: disabled receiver ignores a full frame
    en = 1'b0;
    send_frame(9'h099, 8, 0, 0, 0, 1, -1, 0);
    cmp("R13", "disabled stored", rx_valid_o, 0);
    en = 1'b1;

    // R12: double speed
    dbl = 1'b1;
    expect_char(9'h06d, 0, 0, 0, "R12"); send_frame(9'h06d, 8, 0, 0, 0, 1, -1, 0);
    expect_char(9'h0d2, 0, 0, 0, "R12_glitch"); send_frame(9'h0d2, 8, 0, 0, 0, 1, 2, 0);
    dbl = 1'b0;
    drain();

    // R8: overrun
    hold = 1'b1;
    send_frame(9'h011, 8, 0, 0, 0, 1, -1, 0);
    send_frame(9'h022, 8, 0, 0, 0, 1, -1, 0);
    send_frame(9'h033, 8, 0, 0, 0, 1, -1, 0);
    cmp("R8", "head after overrun", rx_data_o, 'h11);
    cmp("R8", "head overrun flag", overrun_o, 0);
    expect_char(9'h011, 0, 0, 0, "R8");
    expect_char(9'h022, 0, 0, 1, "R8");
    hold = 1'b0;
    drain();

    // R9: read on the write edge while full
    hold = 1'b1;
    send_frame(9'h044, 8, 0, 0, 0, 1, -1, 0);
    send_frame(9'h055, 8, 0, 0, 0, 1, -1, 0);
    cmp("R9", "head before swap", rx_data_o, 'h44);
    send_frame(9'h066, 8, 0, 0, 0, 1, -1, 1);
    cmp("R9", "head after swap", rx_data_o, 'h55);
    cmp("R9", "no overrun after swap", overrun_o, 0);
    expect_char(9'h055, 0, 0, 0, "R9");
    expect_char(9'h066, 0, 0, 0, "R9");
    hold = 1'b0;
    drain();

    // R10: ninth bit
    size = 3'b111;
    expect_char(9'h1a5, 0, 0, 0, "R10"); send_frame(9'h1a5, 9, 0, 0, 0, 1, -1, 0);
    expect_char(9'h05a, 0, 0, 0, "R10"); send_frame(9'h05a, 9, 0, 0, 0, 1, -1, 0);
    drain();

    // R11: multiprocessor filtering
    mpcm = 1'b1;
    send_frame(9'h011, 9, 0, 0, 0, 1, -1, 0);
    cmp("R11", "data before address", rx_valid_o, 0);
    expect_char(9'h13c, 0, 0, 0, "R11_addr_match"); send_frame(9'h13c, 9, 0, 0, 0, 1, -1, 0);
    expect_char(9'h0aa, 0, 0, 0, "R11_data_pass");  send_frame(9'h0aa, 9, 0, 0, 0, 1, -1, 0);
    expect_char(9'h155, 0, 0, 0, "R11_addr_other"); send_frame(9'h155, 9, 0, 0, 0, 1, -1, 0);
    send_frame(9'h077, 9, 0, 0, 0, 1, -1, 0);
    drain();
    cmp("R11", "data after foreign address", rx_valid_o, 0);
    mpcm = 1'b0;
    size = 3'b011;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule